// File: doc/BRIEF.md
# Thread Issue Scheduler

This block decides, once per clock, which hardware thread may send an instruction into a shared single-issue pipeline. It can also decide that no thread issues, which leaves a bubble in the pipeline. It runs in one of three modes, and the mode can be changed at run time.

In rotating-interleave mode, each of N threads owns one slot in every N cycles. In slot-table mode, software fills a table of S entries, and the hardware steps through those entries in order. In ready-priority mode, the block picks among the ready threads with a rotating priority. In the two fixed modes, a slot whose owner is not ready becomes a bubble. The slot is never handed to another thread.

Every decision is registered, and the block drives it out as an issue flag, a bubble flag and a thread ID. A delay line then carries the issue flag and the thread ID alongside the downstream pipeline stages. Each later stage can therefore select the state that belongs to the thread it is working on. Bubbles travel down the delay line as invalid stages.

Top module: `thread_issue_sched`

## Requirements
- R1: When reset is asserted (synchronous, active high), the next clock edge leaves `issue_valid_o`, `bubble_o`, `issue_tid_o` and every delay-line stage at zero. It also marks every slot-table entry invalid, so a full pass in slot-table mode with all threads ready gives S bubbles. The slot pointer restarts at 0 and the priority search restarts at thread 0.
- R2: In rotating-interleave mode (`mode_i` = 0, and also `mode_i` = 3), the slot pointer counts 0,1,…,N-1 and wraps. Slot k belongs to thread k, and the block issues from that thread when its `ready_i` bit is 1.
- R3: In rotating-interleave mode, if the owner of the current slot is not ready, the block issues a bubble, even when other threads are ready.
- R4: In slot-table mode (`mode_i` = 1), the pointer counts 0 to S-1 and wraps. The block issues from the thread named by the current entry when that entry is valid and that thread is ready.
- R5: In slot-table mode, an entry that is invalid, or that names a thread which is not ready, gives a bubble.
- R6: A table write (`tbl_we_i`, with address, thread and valid) is stored at once but used only from the next start of a pass, meaning the next decision at slot 0. Entries used later in the current pass keep their old contents.
- R7: A decision made in a cycle where `mode_i` differs from its value in the previous decision uses slot 0.
- R8: In ready-priority mode (`mode_i` = 2), the block issues from the first ready thread found when searching upward, with wrap, starting just after the thread that last issued in this mode.
- R9: In ready-priority mode, a cycle in which no thread is ready gives a bubble.
- R10: After reset, each decision asserts exactly one of `issue_valid_o` and `bubble_o`. `issue_tid_o` reads 0 whenever `bubble_o` is set.
- R11: Delay-line stage k (0-based) shows the issue flag and thread ID that the issue outputs showed k+1 cycles earlier. Bubbles appear as invalid stages.
- R12: The issue outputs reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0/3 rotating interleave, 1 slot table, 2 ready priority |
| ready_i | input | N_THREADS | One ready bit per thread |
| tbl_we_i | input | 1 | Slot-table write strobe |
| tbl_addr_i | input | clog2(N_SLOTS) | Slot-table entry to write |
| tbl_tid_i | input | TID_W | Thread stored in the entry |
| tbl_valid_i | input | 1 | Valid bit stored in the entry |
| issue_valid_o | output | 1 | A thread issues this cycle |
| bubble_o | output | 1 | The slot is a bubble |
| issue_tid_o | output | TID_W | Issuing thread (0 on a bubble) |
| pipe_valid_o | output | PIPE_DEPTH | Valid flag of each delay-line stage |
| pipe_tid_o | output | PIPE_DEPTH*TID_W | Thread ID of each stage, stage k at bits [k*TID_W +: TID_W] |

## Verification
Each decision appears on the issue outputs one rising edge after the mode, ready and write inputs it used. Delay-line stage k carries that decision k+1 edges later again. The bench changes inputs on the falling edge and reads all outputs on the following falling edge, when exactly one rising edge has passed. A bench model advances its pointers, its shadow and active table copies, and its history of past decisions by one step at a time, so the expected value for every output and stage is due at that sample. Table writes are checked one full pass later, and every mode change is checked at the first slot after it.

// File: rtl/thread_sched_pkg.sv
package thread_sched_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED     = 2'd0,
    MODE_TABLE     = 2'd1,
    MODE_PRIO      = 2'd2,
    MODE_FIXED_ALT = 2'd3
  } sched_mode_e;
endpackage

// File: rtl/thread_slot_table.sv
module thread_slot_table #(
  parameter int N_SLOTS = 8,
  parameter int TID_W   = 2,
  localparam int AW     = $clog2(N_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [TID_W-1:0] wr_tid,
  input  logic             wr_valid,
  input  logic             commit,
  input  logic [AW-1:0]    rd_addr,
  output logic [TID_W-1:0] rd_tid,
  output logic             rd_valid
);
  localparam bit FULL_RANGE = ((1 << AW) == N_SLOTS);

  logic [TID_W-1:0]   sh_tid [N_SLOTS];
  logic [N_SLOTS-1:0] sh_vld;
  logic [TID_W-1:0]   ac_tid [N_SLOTS];
  logic [N_SLOTS-1:0] ac_vld;
  logic               wr_ok;

  generate
    if (FULL_RANGE) begin : g_full
      assign wr_ok = wr_en;
    end else begin : g_part
      assign wr_ok = wr_en && (wr_addr < AW'(N_SLOTS));
    end
  endgenerate

  // thread fields carry no reset; only the valid bits do
  always_ff @(posedge clk) begin
    if (wr_ok) sh_tid[wr_addr] <= wr_tid;
  end

  always_ff @(posedge clk) begin
    if (rst)        sh_vld <= '0;
    else if (wr_ok) sh_vld[wr_addr] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (rst)         ac_vld <= '0;
    else if (commit) ac_vld <= sh_vld;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < N_SLOTS; i++) ac_tid[i] <= sh_tid[i];
    end
  end

  // the first slot of a pass reads the shadow copy that is being committed
  assign rd_tid   = commit ? sh_tid[0] : ac_tid[rd_addr];
  assign rd_valid = commit ? sh_vld[0] : ac_vld[rd_addr];
endmodule

// File: rtl/thread_prio_pick.sv
module thread_prio_pick #(
  parameter int N_THREADS = 4,
  parameter int TID_W     = 2
) (
  input  logic [N_THREADS-1:0] req,
  input  logic [TID_W-1:0]     last,
  output logic                 found,
  output logic [TID_W-1:0]     pick
);
  always_comb begin
    int idx;
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N_THREADS; k++) begin
      idx = (int'(last) + k) % N_THREADS;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = TID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/thread_id_pipe.sv
module thread_id_pipe #(
  parameter int DEPTH = 4,
  parameter int TID_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [TID_W-1:0]       in_tid,
  output logic [DEPTH-1:0]       out_valid,
  output logic [DEPTH*TID_W-1:0] out_tid
);
  logic [DEPTH-1:0] vld_q;
  logic [TID_W-1:0] tid_q [DEPTH];

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      logic             src_v;
      logic [TID_W-1:0] src_t;
      if (k == 0) begin : g_head
        assign src_v = in_valid;
        assign src_t = in_tid;
      end else begin : g_body
        assign src_v = vld_q[k-1];
        assign src_t = tid_q[k-1];
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q[k] <= 1'b0;
          tid_q[k] <= '0;
        end else begin
          vld_q[k] <= src_v;
          tid_q[k] <= src_t;
        end
      end
      assign out_tid[k*TID_W +: TID_W] = tid_q[k];
    end
  endgenerate

  assign out_valid = vld_q;
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
  import thread_sched_pkg::*;
#(
  parameter int N_THREADS  = 4,
  parameter int N_SLOTS    = 8,
  parameter int PIPE_DEPTH = 4,
  localparam int TID_W     = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int SLOT_AW   = $clog2(N_SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  mode_i,
  input  logic [N_THREADS-1:0]        ready_i,
  input  logic                        tbl_we_i,
  input  logic [SLOT_AW-1:0]          tbl_addr_i,
  input  logic [TID_W-1:0]            tbl_tid_i,
  input  logic                        tbl_valid_i,
  output logic                        issue_valid_o,
  output logic                        bubble_o,
  output logic [TID_W-1:0]            issue_tid_o,
  output logic [PIPE_DEPTH-1:0]       pipe_valid_o,
  output logic [PIPE_DEPTH*TID_W-1:0] pipe_tid_o
);
  localparam int PTR_SPAN = (N_THREADS > N_SLOTS) ? N_THREADS : N_SLOTS;
  localparam int PTR_W    = $clog2(PTR_SPAN);

  logic [PTR_W-1:0] slot_q, eff_ptr, nxt_ptr;
  logic [TID_W-1:0] last_q, nxt_last, owner, dec_tid;
  logic [1:0]       mode_q;
  logic             mode_chg, dec_valid;

  logic             tbl_commit, tbl_rd_valid, tbl_tid_ok;
  logic [TID_W-1:0] tbl_rd_tid;
  logic             pick_found;
  logic [TID_W-1:0] pick_tid;

  thread_slot_table #(.N_SLOTS(N_SLOTS), .TID_W(TID_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (tbl_we_i),
    .wr_addr  (tbl_addr_i),
    .wr_tid   (tbl_tid_i),
    .wr_valid (tbl_valid_i),
    .commit   (tbl_commit),
    .rd_addr  (eff_ptr[SLOT_AW-1:0]),
    .rd_tid   (tbl_rd_tid),
    .rd_valid (tbl_rd_valid)
  );

  thread_prio_pick #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_pick (
    .req   (ready_i),
    .last  (last_q),
    .found (pick_found),
    .pick  (pick_tid)
  );

  generate
    if ((1 << TID_W) == N_THREADS) begin : g_tid_full
      assign tbl_tid_ok = 1'b1;
    end else begin : g_tid_part
      assign tbl_tid_ok = (tbl_rd_tid < TID_W'(N_THREADS));
    end
  endgenerate

  assign mode_chg = (mode_i != mode_q);

  always_comb begin
    eff_ptr    = mode_chg ? '0 : slot_q;
    owner      = TID_W'(eff_ptr);
    tbl_commit = 1'b0;
    dec_valid  = 1'b0;
    dec_tid    = '0;
    nxt_ptr    = '0;
    nxt_last   = last_q;
    case (mode_i)
      MODE_TABLE: begin
        tbl_commit = (eff_ptr == '0);
        dec_valid  = tbl_rd_valid && tbl_tid_ok && ready_i[tbl_rd_tid];
        dec_tid    = tbl_rd_tid;
        nxt_ptr    = (eff_ptr == PTR_W'(N_SLOTS - 1)) ? '0 : eff_ptr + 1'b1;
      end
      MODE_PRIO: begin
        dec_valid = pick_found;
        dec_tid   = pick_tid;
        if (pick_found) nxt_last = pick_tid;
      end
      default: begin
        dec_valid = ready_i[owner];
        dec_tid   = owner;
        nxt_ptr   = (eff_ptr == PTR_W'(N_THREADS - 1)) ? '0 : eff_ptr + 1'b1;
      end
    endcase
    if (!dec_valid) dec_tid = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q        <= '0;
      last_q        <= TID_W'(N_THREADS - 1);
      mode_q        <= MODE_FIXED;
      issue_valid_o <= 1'b0;
      bubble_o      <= 1'b0;
      issue_tid_o   <= '0;
    end else begin
      slot_q        <= nxt_ptr;
      last_q        <= nxt_last;
      mode_q        <= mode_i;
      issue_valid_o <= dec_valid;
      bubble_o      <= !dec_valid;
      issue_tid_o   <= dec_tid;
    end
  end

  thread_id_pipe #(.DEPTH(PIPE_DEPTH), .TID_W(TID_W)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (issue_valid_o),
    .in_tid    (issue_tid_o),
    .out_valid (pipe_valid_o),
    .out_tid   (pipe_tid_o)
  );
endmodule

// File: rtl/thread_issue_sched_chk.sv
module thread_issue_sched_chk #(
  parameter int N_THREADS  = 4,
  parameter int PIPE_DEPTH = 4,
  parameter int TID_W      = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic [1:0]                  mode_i,
  input logic [N_THREADS-1:0]        ready_i,
  input logic                        issue_valid_o,
  input logic                        bubble_o,
  input logic [TID_W-1:0]            issue_tid_o,
  input logic [PIPE_DEPTH-1:0]       pipe_valid_o,
  input logic [PIPE_DEPTH*TID_W-1:0] pipe_tid_o
);
  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (issue_valid_o ^ bubble_o));

  // R10
  bubble_tid_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bubble_o |-> (issue_tid_o == '0));

  // R12
  issued_was_ready_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (!issue_valid_o || ((($past(ready_i) >> issue_tid_o) & N_THREADS'(1)) != '0)));

  // R9
  idle_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_i == '0) |=> bubble_o);

  // R8
  prio_single_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == 2'd2) && $onehot(ready_i)) |=>
      (issue_valid_o && ($past(ready_i) == (N_THREADS'(1) << issue_tid_o))));

  // R11
  pipe_head_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pipe_valid_o[0] == $past(issue_valid_o)) &&
              (pipe_tid_o[TID_W-1:0] == $past(issue_tid_o))));

  generate
    if (PIPE_DEPTH > 1) begin : g_shift
      // R11
      pipe_shift_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pipe_valid_o[PIPE_DEPTH-1:1] == $past(pipe_valid_o[PIPE_DEPTH-2:0])) &&
                  (pipe_tid_o[PIPE_DEPTH*TID_W-1:TID_W] ==
                   $past(pipe_tid_o[(PIPE_DEPTH-1)*TID_W-1:0]))));
    end
  endgenerate
endmodule

bind thread_issue_sched thread_issue_sched_chk #(
  .N_THREADS (N_THREADS),
  .PIPE_DEPTH(PIPE_DEPTH),
  .TID_W     (TID_W)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_i       (mode_i),
  .ready_i      (ready_i),
  .issue_valid_o(issue_valid_o),
  .bubble_o     (bubble_o),
  .issue_tid_o  (issue_tid_o),
  .pipe_valid_o (pipe_valid_o),
  .pipe_tid_o   (pipe_tid_o)
);

// File: tb/test_thread_issue_sched.sv
module test_thread_issue_sched;
  localparam int NT = 4;
  localparam int NS = 8;
  localparam int PD = 4;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode_i = 2'd0;
  logic [NT-1:0] ready_i = '0;
  logic          tbl_we_i = 1'b0;
  logic [2:0]    tbl_addr_i = '0;
  logic [TW-1:0] tbl_tid_i = '0;
  logic          tbl_valid_i = 1'b0;
  logic          issue_valid_o, bubble_o;
  logic [TW-1:0] issue_tid_o;
  logic [PD-1:0] pipe_valid_o;
  logic [PD*TW-1:0] pipe_tid_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model state
  int m_ptr = 0, m_prev = 0, m_last = NT - 1;
  int sh_t[NS], sh_v[NS], ac_t[NS], ac_v[NS];
  int hv[PD+1], ht[PD+1];

  always #10 clk = ~clk;

  thread_issue_sched #(.N_THREADS(NT), .N_SLOTS(NS), .PIPE_DEPTH(PD)) i_thread_issue_sched (
    .clk(clk), .rst(rst), .mode_i(mode_i), .ready_i(ready_i),
    .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_tid_i(tbl_tid_i),
    .tbl_valid_i(tbl_valid_i), .issue_valid_o(issue_valid_o), .bubble_o(bubble_o),
    .issue_tid_o(issue_tid_o), .pipe_valid_o(pipe_valid_o), .pipe_tid_o(pipe_tid_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int mi, input int ri, input bit we, input int wa,
                      input int wt, input bit wv, input string tag_ovr);
    int eff, ev, et;
    string tag;
    ev = 0; et = 0;
    eff = (mi != m_prev) ? 0 : m_ptr;
    if (mi == 2) begin
      for (int k = 1; k <= NT; k++) begin
        int idx;
        idx = (m_last + k) % NT;
        if (ev == 0 && ri[idx]) begin ev = 1; et = idx; end
      end
      if (ev != 0) m_last = et;
      m_ptr = 0;
      tag = (ev != 0) ? "R8" : "R9";
    end else if (mi == 1) begin
      if (eff == 0) for (int i = 0; i < NS; i++) begin ac_t[i] = sh_t[i]; ac_v[i] = sh_v[i]; end
      if (ac_v[eff] != 0 && ri[ac_t[eff]]) begin ev = 1; et = ac_t[eff]; end
      m_ptr = (eff + 1) % NS;
      tag = (ev != 0) ? "R4" : "R5";
    end else begin
      if (ri[eff]) begin ev = 1; et = eff; end
      m_ptr = (eff + 1) % NT;
      tag = (ev != 0) ? "R2" : "R3";
    end
    if (we) begin sh_t[wa] = wt; sh_v[wa] = wv; end
    m_prev = mi;
    for (int k = PD; k > 0; k--) begin hv[k] = hv[k-1]; ht[k] = ht[k-1]; end
    hv[0] = ev; ht[0] = et;
    if (tag_ovr != "") tag = tag_ovr;

    mode_i = 2'(mi); ready_i = NT'(ri); tbl_we_i = we;
    tbl_addr_i = 3'(wa); tbl_tid_i = TW'(wt); tbl_valid_i = wv;
    @(posedge clk);
    @(negedge clk);
    tbl_we_i = 1'b0;
    chk(issue_valid_o == ev[0], tag, int'(issue_valid_o), ev);
    chk(bubble_o == !ev[0], {tag, "/R10"}, int'(bubble_o), int'(!ev[0]));
    chk(int'(issue_tid_o) == et, tag, int'(issue_tid_o), et);
    for (int k = 0; k < PD; k++) begin
      chk(pipe_valid_o[k] == hv[k+1][0], "R11", int'(pipe_valid_o[k]), hv[k+1]);
      chk(int'(pipe_tid_o[k*TW +: TW]) == ht[k+1], "R11", int'(pipe_tid_o[k*TW +: TW]), ht[k+1]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin sh_t[i] = 0; sh_v[i] = 0; ac_t[i] = 0; ac_v[i] = 0; end
    for (int k = 0; k <= PD; k++) begin hv[k] = 0; ht[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    chk(issue_valid_o == 1'b0, "R1", int'(issue_valid_o), 0);
    chk(bubble_o == 1'b0, "R1", int'(bubble_o), 0);
    chk(issue_tid_o == '0, "R1", int'(issue_tid_o), 0);
    chk(pipe_valid_o == '0, "R1", int'(pipe_valid_o), 0);
    rst = 1'b0;
    // R1: table entries invalid after reset -> one pass of bubbles
    for (int s = 0; s < NS; s++) step(1, 15, 0, 0, 0, 0, "R1");
    // R7: back to fixed mode restarts at slot 0
    step(0, 15, 0, 0, 0, 0, "R7");
    // R2/R3: every ready pattern, modes 0 and 3
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 16; p++)
        for (int c = 0; c < NT; c++) step(m * 3, p, 0, 0, 0, 0, "");
    // load table while in fixed mode; slot 5 left invalid
    for (int s = 0; s < NS; s++) step(0, 15, 1, s, (s * 3) % NT, s != 5, "");
    // R4/R5: every ready pattern in table mode
    for (int p = 0; p < 16; p++)
      for (int c = 0; c < NS; c++) step(1, p, 0, 0, 0, 0, "");
    // R6: mid-pass rewrites, seen only from the next pass
    step(1, 15, 0, 0, 0, 0, "");
    step(1, 15, 1, 6, 1, 1, "R6");
    step(1, 15, 1, 1, 2, 0, "R6");
    for (int c = 0; c < 2 * NS; c++) step(1, 15, 0, 0, 0, 0, "R6");
    // R7: leave table mode mid-pass and come back
    step(1, 15, 0, 0, 0, 0, "");
    step(1, 15, 0, 0, 0, 0, "");
    step(0, 15, 0, 0, 0, 0, "R7");
    step(0, 15, 0, 0, 0, 0, "");
    step(1, 15, 0, 0, 0, 0, "R7");
    step(3, 15, 0, 0, 0, 0, "R7");
    // R8/R9: ready-priority over every pattern
    for (int p = 0; p < 16; p++)
      for (int c = 0; c < 6; c++) step(2, p, 0, 0, 0, 0, "");
    for (int c = 0; c < 40; c++) step(2, (c * 7 + 3) % 16, 0, 0, 0, 0, "R12");
    for (int c = 0; c < PD + 1; c++) step(0, 0, 0, 0, 0, 0, "");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule